// File: doc/BRIEF.md
# Region Sharing Tracker Table

This block is a set-associative table that sits beside a private last-level cache and keeps coherence information at the granularity of a coarse address region. A region is a power-of-two group of contiguous cache lines (sixteen 64-byte lines by default). For every region it holds, the table keeps a tag, a region state, a vector of the other cores that also cache the region, and the node ID of the core that orders requests for the region. It also keeps, for every line of the region, a valid bit and the data-array way that holds the line.

A cache controller issues one operation per cycle. A lookup returns whether the region and the line are present, the region state, the sharer vector and the root node, plus a route code: satisfy the access locally, send it to the ordering root, go straight to memory, or fetch the sharing information from the directory first. A fill installs the directory's answer. The region starts exclusive when the returned sharer list is empty and shared otherwise. If the fill displaces a valid region, an eviction pulse carries the region number and its root so that the root can drop this core from its list. Other operations add a newly seen requester to a region's sharer vector and mark lines present or absent.

Top module: `region_share_tracker`

## Requirements
- R1: A lookup (req_op 1) compares the tag addr[49:16] against the valid ways of set addr[15:10]. One cycle later rsp_valid is 1 for exactly that cycle, and rsp_region_hit, rsp_state, rsp_sharers and rsp_root describe the matching region. rsp_valid is 0 after every other operation.
- R2: A lookup that finds no region reports rsp_region_hit 0, rsp_line_hit 0, state 0, sharers 0, root 0, dway 0, route 3 (directory), and raises dir_fetch for that cycle. dir_fetch is 0 at all other times.
- R3: A fill (req_op 2) sets the state to exclusive (2) when req_sharers is zero and to shared (1) otherwise. It stores req_sharers as the sharer vector and req_node as the root. State codes are: invalid 0, shared 1, exclusive 2, modified 3.
- R4: The line index is addr[9:6]. Line-set (req_op 4) marks that line valid with data way req_dway. Line-clear (req_op 5) marks it invalid. A lookup reports rsp_line_hit 1 and rsp_dway only when the region hits and the line is valid; otherwise rsp_dway is 0.
- R5: A store lookup (req_store 1) that hits a valid line of an exclusive or modified region reports route 0 (local) and leaves the region modified. The reported state is the state after the lookup.
- R6: A line miss in an exclusive or modified region reports route 2 (memory). In a shared region, a line miss or a store reports route 1 (root). A load that hits a valid line reports route 0 in any state.
- R7: Sharer-add (req_op 3) sets bit req_node of a present region's sharer vector and turns an exclusive or modified region into shared. On a region that is not present it changes nothing.
- R8: A fill of an absent region takes the lowest-numbered invalid way of the set. If no way is invalid, it takes the least recently used way. Lookup hits and fills count as uses; the other operations do not.
- R9: A fill that displaces a valid region raises evict_valid for one cycle, one cycle after the fill, with evict_region = {victim tag, set} and evict_root = the victim's root. A fill into an invalid way or into a present region raises no eviction.
- R10: After reset every way is invalid, all outputs are 0, and the first lookup misses.
- R11: A fill of a region that is already present updates its state, sharers and root in place and keeps its line valid bits and ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation present this cycle |
| req_op | input | 3 | 1 lookup, 2 fill, 3 sharer-add, 4 line-set, 5 line-clear; other codes do nothing |
| req_addr | input | 50 | Physical line address |
| req_store | input | 1 | Lookup is a store |
| req_node | input | 4 | Root node for a fill, or the requester for sharer-add |
| req_sharers | input | 16 | Sharer list from the directory on a fill |
| req_dway | input | 3 | Data-array way for line-set |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_region_hit | output | 1 | Region present |
| rsp_line_hit | output | 1 | Line present in the region |
| rsp_state | output | 3 | Region state after the lookup |
| rsp_sharers | output | 16 | Sharer vector |
| rsp_root | output | 4 | Ordering root node |
| rsp_dway | output | 3 | Data way of a present line |
| rsp_route | output | 2 | 0 local, 1 root, 2 memory, 3 directory |
| dir_fetch | output | 1 | Directory information must be fetched |
| evict_valid | output | 1 | A valid region was displaced |
| evict_region | output | 40 | Region number {tag, set} of the victim |
| evict_root | output | 4 | Root node of the victim |

## Verification
Every result is registered once: lookup responses, dir_fetch and the eviction pulse all appear in the first cycle after the edge that accepts the operation, and they last for only that cycle. The bench drives each operation on a falling edge and samples all outputs on the next falling edge, which lies halfway through that cycle. It then withdraws req_valid before any further edge. Table updates are visible to the very next operation, so a lookup issued right after a fill, sharer-add or line change must already reflect it. The reference model uses timestamps for recency, so the checks also confirm that the ordering is true LRU.

// File: rtl/rgn_pkg.sv
package rgn_pkg;

    typedef enum logic [2:0] {
        OP_NOP        = 3'd0,
        OP_LOOKUP     = 3'd1,
        OP_FILL       = 3'd2,
        OP_SHARER_ADD = 3'd3,
        OP_LINE_SET   = 3'd4,
        OP_LINE_CLR   = 3'd5
    } rgn_op_e;

    typedef enum logic [2:0] {
        RS_INVALID = 3'd0,
        RS_SHARED  = 3'd1,
        RS_EXCL    = 3'd2,
        RS_MOD     = 3'd3
    } rgn_state_e;

    typedef enum logic [1:0] {
        RT_LOCAL     = 2'd0,
        RT_ROOT      = 2'd1,
        RT_MEMORY    = 2'd2,
        RT_DIRECTORY = 2'd3
    } rgn_route_e;

endpackage

// File: rtl/rgn_addr_split.sv
module rgn_addr_split #(
    parameter int PADDR_W    = 50,
    parameter int LINE_OFF_W = 6,
    parameter int LIDX_W     = 4,
    parameter int SET_W      = 6,
    localparam int REG_OFF_W = LINE_OFF_W + LIDX_W,
    localparam int TAG_W     = PADDR_W - REG_OFF_W - SET_W
) (
    input  logic [PADDR_W-1:0] addr,
    output logic [TAG_W-1:0]   tag,
    output logic [SET_W-1:0]   set_idx,
    output logic [LIDX_W-1:0]  line_idx
);
    logic [LINE_OFF_W-1:0] unused_off;

    assign line_idx   = addr[REG_OFF_W-1:LINE_OFF_W];
    assign set_idx    = addr[REG_OFF_W+SET_W-1:REG_OFF_W];
    assign tag        = addr[PADDR_W-1:REG_OFF_W+SET_W];
    assign unused_off = addr[LINE_OFF_W-1:0];
endmodule

// File: rtl/rgn_way_match.sv
module rgn_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 34,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]            way_vld,
    input  logic [TAG_W-1:0]           tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] match;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = way_vld[g] && (way_tag[g] == tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/rgn_victim_pick.sv
module rgn_victim_pick #(
    parameter int WAYS = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]            way_vld,
    input  logic [WAYS-1:0][WAY_W-1:0] way_age,
    output logic [WAY_W-1:0]           victim
);
    logic found;

    always_comb begin
        victim = '0;
        found  = 1'b0;
        // lowest invalid way first
        for (int w = 0; w < WAYS; w++) begin
            if (!way_vld[w] && !found) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
        // otherwise the oldest way
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (way_age[w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/region_share_tracker.sv
module region_share_tracker
    import rgn_pkg::*;
#(
    parameter int PADDR_W      = 50,
    parameter int LINE_BYTES   = 64,
    parameter int REGION_LINES = 16,
    parameter int SETS         = 64,
    parameter int WAYS         = 4,
    parameter int NODES        = 16,
    parameter int DATA_WAYS    = 8,
    localparam int LINE_OFF_W  = $clog2(LINE_BYTES),
    localparam int LIDX_W      = $clog2(REGION_LINES),
    localparam int REG_OFF_W   = LINE_OFF_W + LIDX_W,
    localparam int SET_W       = $clog2(SETS),
    localparam int WAY_W       = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int TAG_W       = PADDR_W - REG_OFF_W - SET_W,
    localparam int NODE_W      = $clog2(NODES),
    localparam int DWAY_W      = $clog2(DATA_WAYS),
    localparam int RGN_W       = PADDR_W - REG_OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [2:0]         req_op,
    input  logic [PADDR_W-1:0] req_addr,
    input  logic               req_store,
    input  logic [NODE_W-1:0]  req_node,
    input  logic [NODES-1:0]   req_sharers,
    input  logic [DWAY_W-1:0]  req_dway,
    output logic               rsp_valid,
    output logic               rsp_region_hit,
    output logic               rsp_line_hit,
    output logic [2:0]         rsp_state,
    output logic [NODES-1:0]   rsp_sharers,
    output logic [NODE_W-1:0]  rsp_root,
    output logic [DWAY_W-1:0]  rsp_dway,
    output logic [1:0]         rsp_route,
    output logic               dir_fetch,
    output logic               evict_valid,
    output logic [RGN_W-1:0]   evict_region,
    output logic [NODE_W-1:0]  evict_root
);

    typedef struct packed {
        logic                                vld;
        rgn_state_e                          st;
        logic [TAG_W-1:0]                    tag;
        logic [NODES-1:0]                    shr;
        logic [NODE_W-1:0]                   root;
        logic [REGION_LINES-1:0]             lv;
        logic [REGION_LINES-1:0][DWAY_W-1:0] lway;
    } ent_t;

    typedef struct packed {
        logic              rsp_valid;
        logic              region_hit;
        logic              line_hit;
        logic [2:0]        state;
        logic [NODES-1:0]  sharers;
        logic [NODE_W-1:0] root;
        logic [DWAY_W-1:0] dway;
        logic [1:0]        route;
        logic              dir_fetch;
        logic              ev_valid;
        logic [RGN_W-1:0]  ev_region;
        logic [NODE_W-1:0] ev_root;
    } out_t;

    ent_t             tbl_q [SETS][WAYS];
    ent_t             tbl_d [SETS][WAYS];
    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic [WAY_W-1:0] age_d [SETS][WAYS];
    out_t             out_q, out_d;

    logic [TAG_W-1:0]            a_tag;
    logic [SET_W-1:0]            a_set;
    logic [LIDX_W-1:0]           a_line;
    logic [WAYS-1:0][TAG_W-1:0]  set_tags;
    logic [WAYS-1:0]             set_vld;
    logic [WAYS-1:0][WAY_W-1:0]  set_age;
    logic                        hit;
    logic [WAY_W-1:0]            hit_way;
    logic [WAY_W-1:0]            victim;

    rgn_addr_split #(
        .PADDR_W(PADDR_W), .LINE_OFF_W(LINE_OFF_W), .LIDX_W(LIDX_W), .SET_W(SET_W)
    ) split_i (
        .addr(req_addr), .tag(a_tag), .set_idx(a_set), .line_idx(a_line)
    );

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            set_tags[w] = tbl_q[a_set][w].tag;
            set_vld[w]  = tbl_q[a_set][w].vld;
            set_age[w]  = age_q[a_set][w];
        end
    end

    rgn_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) match_i (
        .way_tag(set_tags), .way_vld(set_vld), .tag(a_tag),
        .hit(hit), .hit_way(hit_way)
    );

    rgn_victim_pick #(.WAYS(WAYS)) victim_i (
        .way_vld(set_vld), .way_age(set_age), .victim(victim)
    );

    ent_t             cur;
    logic             line_ok;
    logic             excl;
    logic             touch;
    logic [WAY_W-1:0] tw;
    logic [WAY_W-1:0] old_age;
    rgn_state_e       nst;

    always_comb begin
        tbl_d   = tbl_q;
        age_d   = age_q;
        out_d   = '0;
        cur     = tbl_q[a_set][hit_way];
        line_ok = hit && cur.lv[a_line];
        excl    = (cur.st == RS_EXCL) || (cur.st == RS_MOD);
        touch   = 1'b0;
        tw      = hit_way;
        nst     = cur.st;
        old_age = '0;

        if (req_valid) begin
            case (rgn_op_e'(req_op))
                OP_LOOKUP: begin
                    out_d.rsp_valid = 1'b1;
                    if (hit) begin
                        if (line_ok && !req_store) begin
                            out_d.route = RT_LOCAL;
                        end else if (line_ok && excl) begin
                            out_d.route = RT_LOCAL;
                            nst         = RS_MOD;
                        end else if (excl) begin
                            out_d.route = RT_MEMORY;
                        end else begin
                            out_d.route = RT_ROOT;
                        end
                        tbl_d[a_set][hit_way].st = nst;
                        out_d.region_hit = 1'b1;
                        out_d.line_hit   = line_ok;
                        out_d.dway       = line_ok ? cur.lway[a_line] : '0;
                        out_d.state      = nst;
                        out_d.sharers    = cur.shr;
                        out_d.root       = cur.root;
                        touch            = 1'b1;
                    end else begin
                        out_d.route     = RT_DIRECTORY;
                        out_d.dir_fetch = 1'b1;
                    end
                end
                OP_FILL: begin
                    if (!hit) begin
                        tw = victim;
                        if (set_vld[victim]) begin
                            out_d.ev_valid  = 1'b1;
                            out_d.ev_region = {tbl_q[a_set][victim].tag, a_set};
                            out_d.ev_root   = tbl_q[a_set][victim].root;
                        end
                        tbl_d[a_set][tw].lv   = '0;
                        tbl_d[a_set][tw].lway = '0;
                    end
                    tbl_d[a_set][tw].vld  = 1'b1;
                    tbl_d[a_set][tw].tag  = a_tag;
                    tbl_d[a_set][tw].st   = (req_sharers == '0) ? RS_EXCL : RS_SHARED;
                    tbl_d[a_set][tw].shr  = req_sharers;
                    tbl_d[a_set][tw].root = req_node;
                    touch = 1'b1;
                end
                OP_SHARER_ADD: begin
                    if (hit) begin
                        tbl_d[a_set][hit_way].shr[req_node] = 1'b1;
                        tbl_d[a_set][hit_way].st            = RS_SHARED;
                    end
                end
                OP_LINE_SET: begin
                    if (hit) begin
                        tbl_d[a_set][hit_way].lv[a_line]   = 1'b1;
                        tbl_d[a_set][hit_way].lway[a_line] = req_dway;
                    end
                end
                OP_LINE_CLR: begin
                    if (hit) tbl_d[a_set][hit_way].lv[a_line] = 1'b0;
                end
                default: ;
            endcase
        end

        if (touch) begin
            old_age = age_q[a_set][tw];
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == tw) begin
                    age_d[a_set][w] = '0;
                end else if (age_q[a_set][w] < old_age) begin
                    age_d[a_set][w] = age_q[a_set][w] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tbl_q[s][w] <= '0;
                    age_q[s][w] <= WAY_W'(w);
                end
            end
            out_q <= '0;
        end else begin
            tbl_q <= tbl_d;
            age_q <= age_d;
            out_q <= out_d;
        end
    end

    assign rsp_valid      = out_q.rsp_valid;
    assign rsp_region_hit = out_q.region_hit;
    assign rsp_line_hit   = out_q.line_hit;
    assign rsp_state      = out_q.state;
    assign rsp_sharers    = out_q.sharers;
    assign rsp_root       = out_q.root;
    assign rsp_dway       = out_q.dway;
    assign rsp_route      = out_q.route;
    assign dir_fetch      = out_q.dir_fetch;
    assign evict_valid    = out_q.ev_valid;
    assign evict_region   = out_q.ev_region;
    assign evict_root     = out_q.ev_root;

endmodule

// File: rtl/rgn_share_checker.sv
module rgn_share_checker #(
    parameter int NODES = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [2:0]       req_op,
    input logic             req_store,
    input logic             rsp_valid,
    input logic             rsp_region_hit,
    input logic             rsp_line_hit,
    input logic [2:0]       rsp_state,
    input logic [NODES-1:0] rsp_sharers,
    input logic [1:0]       rsp_route,
    input logic             dir_fetch,
    input logic             evict_valid
);

    p_rsp_from_lookup_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_op == 3'd1));

    p_fetch_on_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dir_fetch |-> (rsp_valid && !rsp_region_hit && rsp_route == 2'd3));

    p_excl_no_sharers_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_region_hit && (rsp_state == 3'd2 || rsp_state == 3'd3))
            |-> (rsp_sharers == '0));

    p_line_in_region_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_line_hit) |-> rsp_region_hit);

    p_local_store_mod_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_route == 2'd0 && $past(req_store)) |-> (rsp_state == 3'd3));

    p_memory_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_route == 2'd2)
            |-> (!rsp_line_hit && (rsp_state == 3'd2 || rsp_state == 3'd3)));

    p_shared_has_sharers_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_region_hit && rsp_state == 3'd1) |-> (rsp_sharers != '0));

    p_evict_from_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> $past(req_valid && req_op == 3'd2));

endmodule

bind region_share_tracker rgn_share_checker #(.NODES(NODES)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_store(req_store), .rsp_valid(rsp_valid), .rsp_region_hit(rsp_region_hit),
    .rsp_line_hit(rsp_line_hit), .rsp_state(rsp_state), .rsp_sharers(rsp_sharers),
    .rsp_route(rsp_route), .dir_fetch(dir_fetch), .evict_valid(evict_valid)
);

// File: tb/region_share_tracker_tb_top.sv
`timescale 1ns/1ps
module region_share_tracker_tb_top;

    localparam int NS = 64;
    localparam int NW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [49:0] req_addr = '0;
    logic        req_store = 1'b0;
    logic [3:0]  req_node = '0;
    logic [15:0] req_sharers = '0;
    logic [2:0]  req_dway = '0;
    logic        rsp_valid, rsp_region_hit, rsp_line_hit, dir_fetch, evict_valid;
    logic [2:0]  rsp_state, rsp_dway;
    logic [15:0] rsp_sharers;
    logic [3:0]  rsp_root, evict_root;
    logic [1:0]  rsp_route;
    logic [39:0] evict_region;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    region_share_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_store(req_store), .req_node(req_node),
        .req_sharers(req_sharers), .req_dway(req_dway), .rsp_valid(rsp_valid),
        .rsp_region_hit(rsp_region_hit), .rsp_line_hit(rsp_line_hit),
        .rsp_state(rsp_state), .rsp_sharers(rsp_sharers), .rsp_root(rsp_root),
        .rsp_dway(rsp_dway), .rsp_route(rsp_route), .dir_fetch(dir_fetch),
        .evict_valid(evict_valid), .evict_region(evict_region), .evict_root(evict_root)
    );

    // reference model, recency kept as timestamps
    bit          m_vld  [NS][NW];
    logic [33:0] m_tag  [NS][NW];
    logic [2:0]  m_st   [NS][NW];
    logic [15:0] m_shr  [NS][NW];
    logic [3:0]  m_root [NS][NW];
    logic [15:0] m_lv   [NS][NW];
    logic [2:0]  m_lway [NS][NW][16];
    int          m_ts   [NS][NW];
    int          now_t = 0;

    task automatic chk(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [49:0] mk_addr(input int tag, input int set, input int line);
        return {34'(tag), 6'(set), 4'(line), 6'h15};
    endfunction

    task automatic run_op(input string rq, input logic [2:0] op, input logic [49:0] addr,
                          input logic st, input logic [3:0] node,
                          input logic [15:0] shr, input logic [2:0] dw);
        int s, li, hw, tw;
        bit hit, lh, ex;
        logic [33:0] tg;
        logic e_rv, e_rh, e_lh, e_df, e_ev;
        logic [2:0] e_st, e_dw;
        logic [15:0] e_shr;
        logic [3:0] e_root, e_evroot;
        logic [1:0] e_rt;
        logic [39:0] e_evreg;
        s = int'(addr[15:10]); li = int'(addr[9:6]); tg = addr[49:16];
        hit = 0; hw = 0;
        for (int w = 0; w < NW; w++) if (m_vld[s][w] && m_tag[s][w] == tg) begin hit = 1; hw = w; end
        e_rv = 0; e_rh = 0; e_lh = 0; e_df = 0; e_ev = 0; e_st = 0; e_dw = 0;
        e_shr = 0; e_root = 0; e_evroot = 0; e_rt = 0; e_evreg = 0;
        case (op)
            3'd1: begin
                e_rv = 1;
                if (hit) begin
                    lh = m_lv[s][hw][li];
                    ex = (m_st[s][hw] == 3'd2) || (m_st[s][hw] == 3'd3);
                    if (lh && !st) e_rt = 2'd0;
                    else if (lh && ex) begin e_rt = 2'd0; m_st[s][hw] = 3'd3; end
                    else if (ex) e_rt = 2'd2;
                    else e_rt = 2'd1;
                    e_rh = 1; e_lh = lh; e_dw = lh ? m_lway[s][hw][li] : 3'd0;
                    e_st = m_st[s][hw]; e_shr = m_shr[s][hw]; e_root = m_root[s][hw];
                    now_t++; m_ts[s][hw] = now_t;
                end else begin
                    e_rt = 2'd3; e_df = 1;
                end
            end
            3'd2: begin
                if (hit) tw = hw;
                else begin
                    tw = -1;
                    for (int w = NW - 1; w >= 0; w--) if (!m_vld[s][w]) tw = w;
                    if (tw < 0) begin
                        tw = 0;
                        for (int w = 1; w < NW; w++) if (m_ts[s][w] < m_ts[s][tw]) tw = w;
                        e_ev = 1; e_evreg = {m_tag[s][tw], 6'(s)}; e_evroot = m_root[s][tw];
                    end
                    m_lv[s][tw] = 0;
                    for (int l = 0; l < 16; l++) m_lway[s][tw][l] = 0;
                end
                m_vld[s][tw] = 1; m_tag[s][tw] = tg; m_shr[s][tw] = shr; m_root[s][tw] = node;
                m_st[s][tw] = (shr == 0) ? 3'd2 : 3'd1;
                now_t++; m_ts[s][tw] = now_t;
            end
            3'd3: if (hit) begin m_shr[s][hw][node] = 1'b1; m_st[s][hw] = 3'd1; end
            3'd4: if (hit) begin m_lv[s][hw][li] = 1'b1; m_lway[s][hw][li] = dw; end
            3'd5: if (hit) m_lv[s][hw][li] = 1'b0;
            default: ;
        endcase
        req_valid = 1; req_op = op; req_addr = addr; req_store = st;
        req_node = node; req_sharers = shr; req_dway = dw;
        @(negedge clk);
        req_valid = 0;
        chk(rq, "rsp_valid", 64'(rsp_valid), 64'(e_rv));
        chk("R9", "evict_valid", 64'(evict_valid), 64'(e_ev));
        if (e_ev) begin
            chk("R9", "evict_region", 64'(evict_region), 64'(e_evreg));
            chk("R9", "evict_root", 64'(evict_root), 64'(e_evroot));
        end
        chk("R2", "dir_fetch", 64'(dir_fetch), 64'(e_df));
        if (e_rv) begin
            chk(rq, "region_hit", 64'(rsp_region_hit), 64'(e_rh));
            chk(rq, "line_hit", 64'(rsp_line_hit), 64'(e_lh));
            chk(rq, "state", 64'(rsp_state), 64'(e_st));
            chk(rq, "sharers", 64'(rsp_sharers), 64'(e_shr));
            chk(rq, "root", 64'(rsp_root), 64'(e_root));
            chk(rq, "dway", 64'(rsp_dway), 64'(e_dw));
            chk(rq, "route", 64'(rsp_route), 64'(e_rt));
        end
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [2:0] op;
        int r;
        void'($urandom(32'd20240611));
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin
                m_vld[s][w] = 0; m_lv[s][w] = 0; m_ts[s][w] = 0;
            end
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state at the ports
        chk("R10", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R10", "evict_valid", 64'(evict_valid), 64'd0);
        chk("R10", "dir_fetch", 64'(dir_fetch), 64'd0);
        run_op("R10", 3'd1, mk_addr(1, 0, 5), 0, 0, 0, 0);
        // R3 exclusive fill, R6 memory route, R4 line set, R5 local upgrade
        run_op("R3", 3'd2, mk_addr(1, 0, 0), 0, 4'd3, 16'h0000, 0);
        run_op("R6", 3'd1, mk_addr(1, 0, 5), 0, 0, 0, 0);
        run_op("R4", 3'd4, mk_addr(1, 0, 5), 0, 0, 0, 3'd6);
        run_op("R4", 3'd1, mk_addr(1, 0, 5), 0, 0, 0, 0);
        run_op("R5", 3'd1, mk_addr(1, 0, 5), 1, 0, 0, 0);
        // R7 sharer add demotes to shared; R6 store in shared goes to root
        run_op("R7", 3'd3, mk_addr(1, 0, 0), 0, 4'd9, 0, 0);
        run_op("R7", 3'd1, mk_addr(1, 0, 5), 0, 0, 0, 0);
        run_op("R6", 3'd1, mk_addr(1, 0, 5), 1, 0, 0, 0);
        run_op("R4", 3'd5, mk_addr(1, 0, 5), 0, 0, 0, 0);
        run_op("R4", 3'd1, mk_addr(1, 0, 5), 0, 0, 0, 0);
        // R7 sharer add on absent region changes nothing
        run_op("R7", 3'd3, mk_addr(2, 0, 0), 0, 4'd1, 0, 0);
        run_op("R7", 3'd1, mk_addr(1, 0, 5), 0, 0, 0, 0);
        run_op("R7", 3'd1, mk_addr(2, 0, 0), 0, 0, 0, 0);
        // R8/R9 placement and LRU eviction
        run_op("R3", 3'd2, mk_addr(2, 0, 0), 0, 4'd4, 16'h0010, 0);
        run_op("R9", 3'd2, mk_addr(3, 0, 0), 0, 4'd5, 16'h0001, 0);
        run_op("R9", 3'd2, mk_addr(4, 0, 0), 0, 4'd6, 16'h0000, 0);
        run_op("R8", 3'd1, mk_addr(1, 0, 1), 0, 0, 0, 0);
        run_op("R9", 3'd2, mk_addr(5, 0, 0), 0, 4'd7, 16'h0100, 0);
        run_op("R8", 3'd1, mk_addr(2, 0, 0), 0, 0, 0, 0);
        // R11 in-place refill keeps line state
        run_op("R11", 3'd4, mk_addr(1, 0, 2), 0, 0, 0, 3'd2);
        run_op("R11", 3'd2, mk_addr(1, 0, 0), 0, 4'd8, 16'h0000, 0);
        run_op("R11", 3'd1, mk_addr(1, 0, 2), 1, 0, 0, 0);
        // random mix over a few crowded sets
        for (int i = 0; i < 3000; i++) begin
            r = int'($urandom_range(99));
            if (r < 40) op = 3'd1;
            else if (r < 65) op = 3'd2;
            else if (r < 80) op = 3'd3;
            else if (r < 92) op = 3'd4;
            else op = 3'd5;
            run_op("R1", op,
                   mk_addr(int'($urandom_range(6, 1)), int'($urandom_range(1)),
                           int'($urandom_range(15))),
                   1'($urandom), 4'($urandom),
                   ($urandom_range(9) < 3) ? 16'h0 : 16'($urandom), 3'($urandom));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule